// File: doc/BRIEF.md
# Register-File and ALU Datapath

This block is a narrow datapath. A small register file feeds both operands of a combinational arithmetic and logic unit, and the unit's result can be stored back into any register. Two read selects pick the operands independently in every cycle. A 4-bit operation code picks what the unit computes. When the write enable is high, the result is stored at the clock edge into the register that the write select names. The same edge also captures the zero and carry flags.

All selects, the operation code and the write enable are driven directly by the surrounding logic. There is no fetch, decode or program sequencing inside the block. A synchronous reset loads each register with its index plus one and clears the captured flags. The result and both flags also appear combinationally, so a caller can inspect an operation before committing it.

Top module: `rfalu_core`

## Requirements
- R1: While the synchronous reset is high at a clock edge, register n is loaded with n+1 (register 0 = 1, register 1 = 2, register 2 = 3, register 3 = 4), and both captured flags are cleared to 0.
- R2: The two read ports show, combinationally and independently, the registers named by their own 2-bit selects.
- R3: A register changes only at an edge where the write enable is high and reset is low. It then takes the ALU result, and only the register named by the write select changes.
- R4: Operation code 0000 adds, with carry equal to bit 4 of the sum. Code 0001 subtracts the second operand from the first modulo 16, with carry set when the first operand is less than the second (borrow).
- R5: Code 0010 gives the low 4 bits of the product, with carry set when the upper product bits are nonzero. Code 0011 gives the integer quotient with carry 0. A zero divisor gives 4'hF with carry 1.
- R6: Codes 0100 AND, 0101 OR, 0110 XOR, 0111 XNOR and 1000 NOT (of the first operand) produce a carry of 0.
- R7: Code 1001 shifts the first operand right by one, with carry equal to its bit 0. Code 1010 shifts it left by one, with carry equal to its bit 3.
- R8: Codes 1011 through 1111 produce a result of 0 with carry 0.
- R9: The zero flag is high exactly when the 4-bit result is 0, for every code.
- R10: The captured zero and carry flags load the combinational flags at every edge where the write enable is high, and otherwise hold.
- R11: Reading a register in the same cycle it is written returns the old value. The new value appears from the next cycle on, because there is no bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdSelA | input | 2 | Select for the first operand |
| rdSelB | input | 2 | Select for the second operand |
| wrSel | input | 2 | Register to write back into |
| wrEn | input | 1 | Write-back and flag capture enable |
| opCode | input | 4 | Operation code |
| rdDataA | output | 4 | First operand value |
| rdDataB | output | 4 | Second operand value |
| aluResult | output | 4 | Combinational result |
| zeroFlag | output | 1 | Combinational zero flag |
| carryFlag | output | 1 | Combinational carry flag |
| zeroFlagReg | output | 1 | Captured zero flag |
| carryFlagReg | output | 1 | Captured carry flag |

## Verification
The bench builds the block with its default parameters: a data width of 4 and four registers. These values keep every operand pair small enough for random stimulus to reach each corner. That includes a zero divisor, a product overflow, borrows, shifted-out bits and all five unused codes. The narrow select width also means that a write and a read often hit the same register, which exercises the no-bypass rule many times.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_XNOR = 4'd7,
    OP_NOT  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SHL  = 4'd10
  } aluOp_e;

  localparam int OP_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic initRegs;
    logic wrStrobe;
    logic flagLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/rfalu_alu.sv
module rfalu_alu #(
  parameter int DATA_W = 4
) (
  input  logic [rfalu_pkg::OP_W-1:0] opCode,
  input  logic [DATA_W-1:0]          opA,
  input  logic [DATA_W-1:0]          opB,
  output logic [DATA_W-1:0]          result,
  output logic                       carry,
  output logic                       zero
);
  import rfalu_pkg::*;

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   sumExt;
  logic [PROD_W-1:0] prodFull;

  assign sumExt   = {1'b0, opA} + {1'b0, opB};
  assign prodFull = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};

  always_comb begin
    result = '0;
    carry  = 1'b0;
    case (opCode)
      OP_ADD: begin
        result = sumExt[DATA_W-1:0];
        carry  = sumExt[DATA_W];
      end
      OP_SUB: begin
        result = opA - opB;
        carry  = (opA < opB);
      end
      OP_MUL: begin
        result = prodFull[DATA_W-1:0];
        carry  = |prodFull[PROD_W-1:DATA_W];
      end
      OP_DIV: begin
        if (opB == '0) begin
          result = '1;
          carry  = 1'b1;
        end else begin
          result = opA / opB;
        end
      end
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      OP_XNOR: result = ~(opA ^ opB);
      OP_NOT:  result = ~opA;
      OP_SHR: begin
        result = opA >> 1;
        carry  = opA[0];
      end
      OP_SHL: begin
        result = opA << 1;
        carry  = opA[DATA_W-1];
      end
      default: begin
        result = '0;
        carry  = 1'b0;
      end
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/rfalu_ctrl.sv
module rfalu_ctrl (
  input  logic                     rst,
  input  logic                     wrEn,
  output rfalu_pkg::ctrlStrobes_t  strobes
);
  // reset has priority over any write request
  always_comb begin
    strobes.initRegs = rst;
    strobes.wrStrobe = wrEn & ~rst;
    strobes.flagLoad = wrEn & ~rst;
  end

endmodule

// File: rtl/rfalu_datapath.sv
module rfalu_datapath #(
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 4
) (
  input  logic                          clk,
  input  rfalu_pkg::ctrlStrobes_t       strobes,
  input  logic [$clog2(NUM_REGS)-1:0]   rdSelA,
  input  logic [$clog2(NUM_REGS)-1:0]   rdSelB,
  input  logic [$clog2(NUM_REGS)-1:0]   wrSel,
  input  logic [rfalu_pkg::OP_W-1:0]    opCode,
  output logic [DATA_W-1:0]             rdDataA,
  output logic [DATA_W-1:0]             rdDataB,
  output logic [DATA_W-1:0]             aluResult,
  output logic                          zeroFlag,
  output logic                          carryFlag,
  output logic                          zeroFlagReg,
  output logic                          carryFlagReg
);
  import rfalu_pkg::*;

  localparam int SEL_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [DATA_W-1:0] INIT_VAL = DATA_W'(gi + 1);
      always_ff @(posedge clk) begin
        if (strobes.initRegs)
          regs[gi] <= INIT_VAL;
        else if (strobes.wrStrobe && (wrSel == SEL_W'(gi)))
          regs[gi] <= aluResult;
      end

      a_r1_reset_value: assert property (@(posedge clk)
        strobes.initRegs |=> (regs[gi] == INIT_VAL));
    end
  endgenerate

  // no bypass: reads see only the stored state
  assign rdDataA = regs[rdSelA];
  assign rdDataB = regs[rdSelB];

  rfalu_alu #(.DATA_W(DATA_W)) u_alu (
    .opCode (opCode),
    .opA    (rdDataA),
    .opB    (rdDataB),
    .result (aluResult),
    .carry  (carryFlag),
    .zero   (zeroFlag)
  );

  always_ff @(posedge clk) begin
    if (strobes.initRegs) begin
      zeroFlagReg  <= 1'b0;
      carryFlagReg <= 1'b0;
    end else if (strobes.flagLoad) begin
      zeroFlagReg  <= zeroFlag;
      carryFlagReg <= carryFlag;
    end
  end

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (strobes.initRegs)
    !strobes.wrStrobe |=> $stable(regs));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (strobes.initRegs)
    strobes.wrStrobe |=> (regs[$past(wrSel)] == $past(aluResult)));

  a_r10_flag_capture: assert property (@(posedge clk) disable iff (strobes.initRegs)
    strobes.flagLoad |=> (zeroFlagReg == $past(zeroFlag) && carryFlagReg == $past(carryFlag)));

  a_r10_flag_hold: assert property (@(posedge clk) disable iff (strobes.initRegs)
    !strobes.flagLoad |=> ($stable(zeroFlagReg) && $stable(carryFlagReg)));

  a_r5_div_by_zero: assert property (@(posedge clk) disable iff (strobes.initRegs)
    (opCode == OP_DIV && rdDataB == '0) |-> (aluResult == '1 && carryFlag));

  a_r8_unused_code: assert property (@(posedge clk) disable iff (strobes.initRegs)
    (opCode > OP_SHL) |-> (aluResult == '0 && !carryFlag && zeroFlag));

endmodule

// File: rtl/rfalu_core.sv
module rfalu_core #(
  parameter int DATA_W   = 4,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    rdSelA,
  input  logic [SEL_W-1:0]    rdSelB,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic                wrEn,
  input  logic [3:0]          opCode,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB,
  output logic [DATA_W-1:0]   aluResult,
  output logic                zeroFlag,
  output logic                carryFlag,
  output logic                zeroFlagReg,
  output logic                carryFlagReg
);
  rfalu_pkg::ctrlStrobes_t strobes;

  rfalu_ctrl u_ctrl (
    .rst     (rst),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  rfalu_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk          (clk),
    .strobes      (strobes),
    .rdSelA       (rdSelA),
    .rdSelB       (rdSelB),
    .wrSel        (wrSel),
    .opCode       (opCode),
    .rdDataA      (rdDataA),
    .rdDataB      (rdDataB),
    .aluResult    (aluResult),
    .zeroFlag     (zeroFlag),
    .carryFlag    (carryFlag),
    .zeroFlagReg  (zeroFlagReg),
    .carryFlagReg (carryFlagReg)
  );

endmodule

// File: tb/rfalu_core_tb.sv
module rfalu_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] rdSelA, rdSelB, wrSel;
  logic       wrEn;
  logic [3:0] opCode;
  logic [3:0] rdDataA, rdDataB, aluResult;
  logic       zeroFlag, carryFlag, zeroFlagReg, carryFlagReg;

  int checks = 0;
  int fails  = 0;

  // reference state
  int mRegs[4];
  int mZeroReg, mCarryReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfalu_core u_dut (
    .clk(clk), .rst(rst), .rdSelA(rdSelA), .rdSelB(rdSelB), .wrSel(wrSel),
    .wrEn(wrEn), .opCode(opCode), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .aluResult(aluResult), .zeroFlag(zeroFlag), .carryFlag(carryFlag),
    .zeroFlagReg(zeroFlagReg), .carryFlagReg(carryFlagReg)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string reqOf(input int op);
    case (op)
      0, 1:          return "R4";
      2, 3:          return "R5";
      4, 5, 6, 7, 8: return "R6";
      9, 10:         return "R7";
      default:       return "R8";
    endcase
  endfunction

  // behavioural model of one operation
  function automatic void refAlu(input int op, input int a, input int b,
                                 output int r, output int c);
    int p;
    c = 0;
    case (op)
      0: begin p = a + b; r = p % 16; c = (p > 15); end
      1: begin r = (a - b + 16) % 16; c = (a < b); end
      2: begin p = a * b; r = p % 16; c = (p > 15); end
      3: begin if (b == 0) begin r = 15; c = 1; end else r = a / b; end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = 15 - (a ^ b);
      8: r = 15 - a;
      9: begin r = a / 2; c = a % 2; end
      10: begin r = (a * 2) % 16; c = a / 8; end
      default: r = 0;
    endcase
  endfunction

  task automatic step(input int op, input int a, input int b, input int w,
                      input bit we, input string rdTag);
    int er, ec;
    @(negedge clk);
    opCode = op[3:0]; rdSelA = a[1:0]; rdSelB = b[1:0]; wrSel = w[1:0]; wrEn = we;
    #1;
    refAlu(op, mRegs[a], mRegs[b], er, ec);
    check(rdTag, "read A", int'(rdDataA), mRegs[a]);
    check("R2",  "read B", int'(rdDataB), mRegs[b]);
    check(reqOf(op), "result", int'(aluResult), er);
    check(reqOf(op), "carry", int'(carryFlag), ec);
    check("R9", "zero", int'(zeroFlag), int'(er == 0));
    check("R10", "zero reg", int'(zeroFlagReg), mZeroReg);
    check("R10", "carry reg", int'(carryFlagReg), mCarryReg);
    @(posedge clk);
    if (we) begin
      mRegs[w]  = er;
      mZeroReg  = (er == 0);
      mCarryReg = ec;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; opCode = '0; rdSelA = '0; rdSelB = '0; wrSel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) mRegs[i] = i + 1;
    mZeroReg = 0; mCarryReg = 0;

    // R1: reset values through the read ports
    for (int i = 0; i < 4; i++) begin
      rdSelA = i[1:0];
      #1;
      check("R1", "reset value", int'(rdDataA), i + 1);
    end
    check("R1", "zero reg reset", int'(zeroFlagReg), 0);
    check("R1", "carry reg reset", int'(carryFlagReg), 0);

    // directed corners
    step(0, 3, 3, 0, 1, "R2");      // 4+4=8 into reg0
    step(0, 0, 0, 1, 1, "R2");      // 8+8=16 -> 0, carry into reg1 (R4, R9)
    step(1, 1, 2, 2, 1, "R2");      // 0-3 borrow (R4)
    step(3, 0, 1, 3, 0, "R2");      // divide by zero, no write (R5, R3)
    step(2, 0, 2, 3, 1, "R2");      // 8*13 overflow (R5)
    step(10, 0, 0, 0, 1, "R11");    // reg0 written while read: old value seen (R11)
    step(4, 0, 0, 0, 0, "R11");     // next cycle sees the new value
    step(9, 2, 2, 2, 1, "R7");      // right shift carry out of bit 0
    step(13, 3, 2, 1, 1, "R8");     // unused code
    step(8, 1, 1, 1, 0, "R3");      // no write: flags and regs hold (R10)
    step(7, 3, 3, 2, 1, "R6");      // XNOR equal operands -> 15

    // random sweep over all codes and selects
    for (int n = 0; n < 2000; n++) begin
      step($urandom_range(15), $urandom_range(3), $urandom_range(3),
           $urandom_range(3), bit'($urandom_range(1)), "R2");
    end

    // reset again mid-run (R1)
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; opCode = 4'd0;
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      mRegs[i] = i + 1;
      rdSelA = i[1:0];
      #1;
      check("R1", "re-reset value", int'(rdDataA), i + 1);
    end
    mZeroReg = 0; mCarryReg = 0;
    check("R1", "zero reg re-reset", int'(zeroFlagReg), 0);
    check("R1", "carry reg re-reset", int'(carryFlagReg), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule